// File: doc/BRIEF.md
# World-Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache for a processor that runs in two security worlds, secure and normal. A lookup presents a virtual page number together with the current world. In the same cycle the block answers with a hit flag, the cached physical page number, and a flag that says whether the outgoing memory access is non-secure. Pages are 4 KB and addresses are 32 bits, so both page numbers are 20 bits wide.

An external page-table walker loads translations through the fill port. Each fill carries the descriptor's non-secure bit and the world that was current when the walk ran. Every entry keeps the world it was loaded in, and it answers only lookups made from that same world. Normal-world translations always yield non-secure accesses. Secure-world translations return the non-secure bit from their descriptor, so secure software can reach either kind of memory page by page. A flush input drops the entries of one world or of both worlds.

The world bit is 1 for secure and 0 for normal. On the `lk_ns` output, 1 means non-secure.

Top module: `wtlb_top`

## Requirements
- R1: A fill stores its entry with the world tag given on `fl_world`. After a secure fill the page hits for a secure lookup. After a normal fill it hits for a normal lookup.
- R2: A lookup hits only on a valid entry whose page and world tag both equal the lookup's. A page filled in one world misses when it is looked up from the other world.
- R3: When a normal-world lookup (`lk_world`=0) hits, `lk_ns` is 1, whatever descriptor bit was supplied with the fill.
- R4: A secure fill stores `fl_ns`. When a secure lookup hits, `lk_ns` equals that stored bit.
- R5: A lookup is combinational. On a hit, `lk_ppn` shows the cached physical page in the same cycle the inputs are presented.
- R6: The same virtual page can be resident at the same time as one secure entry and one normal entry. The two entries return their own contents independently.
- R7: A fill whose page and world match a valid entry overwrites that entry in place, so at most one entry ever matches a lookup.
- R8: A fill that matches no entry goes to the lowest-numbered invalid entry. When all entries are valid it replaces the entry at a victim pointer. That pointer starts at entry 0 and advances by one, wrapping around, after each such replacement.
- R9: A flush pulse with `inv_sel` = 01 drops all secure entries, 10 drops all normal entries, and 11 drops every entry. The flush takes effect at one clock edge.
- R10: When a fill and a lookup of the same entry occur in one cycle, the lookup returns the old contents. The new contents appear after the clock edge.
- R11: A synchronous active-low reset invalidates every entry and returns the victim pointer to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_world | input | 1 | Current world for the lookup (1 secure, 0 normal) |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_ppn | output | 20 | Physical page number on a hit |
| lk_ns | output | 1 | Outgoing access is non-secure |
| fl_en | input | 1 | Write a translation this cycle |
| fl_vpn | input | 20 | Virtual page number being filled |
| fl_ppn | input | 20 | Physical page number being filled |
| fl_ns | input | 1 | Non-secure bit from the descriptor |
| fl_world | input | 1 | World that was current during the walk |
| inv_en | input | 1 | Flush pulse |
| inv_sel | input | 2 | Flush selection: 01 secure, 10 normal, 11 both |

## Verification
A wrong world tag or a wrong valid bit shows up at the ports on the very next lookup. It appears either as a hit from the wrong world or as a miss where a hit is expected, one cycle after the fill or flush that caused it. A wrong victim pointer is harder to spot, because it surfaces only once the array is full. The bench therefore fills all entries and then replaces them in order, and checks which old page disappears. A stored non-secure bit that is lost or not forced shows up on `lk_ns` on the first hit of the affected entry.

// File: rtl/wtlb_pkg.sv
// Shared widths, entry layout and encodings for the world-tagged TLB.
// Assumes 4 KB pages on 32-bit addresses (20-bit page numbers).
package wtlb_pkg;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    localparam logic WORLD_SEC = 1'b1;
    localparam logic WORLD_NRM = 1'b0;

    // Flush selection: bit 0 selects secure entries, bit 1 selects normal entries.
    localparam int INV_SEC_BIT = 0;
    localparam int INV_NRM_BIT = 1;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             world;
        logic             ns;
    } tlb_ent_t;
endpackage

// File: rtl/wtlb_match.sv
// Parallel tag compare: flags each valid entry whose page and world equal the key.
// Assumes the caller keeps at most one matching entry per (page, world) pair.
module wtlb_match
    import wtlb_pkg::*;
#(
    parameter int N = 8
) (
    input  tlb_ent_t [N-1:0] ents,
    input  logic [N-1:0]     valid,
    input  logic [VPN_W-1:0] key_vpn,
    input  logic             key_world,
    output logic [N-1:0]     hit
);
    // One comparator per entry.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = valid[i] && (ents[i].vpn == key_vpn) && (ents[i].world == key_world);
    end
endmodule

// File: rtl/wtlb_slot_pick.sv
// Chooses the entry a fill writes: a matching entry first, then the lowest
// invalid entry, then a round-robin victim. Holds the victim pointer.
// Assumes fill_match is one-hot or zero.
module wtlb_slot_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fl_en,
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  fill_match,
    output logic [IW-1:0] slot
);
    logic [IW-1:0] ptr_q;
    logic          replace;

    // Priority selection of the target slot.
    always_comb begin
        slot    = ptr_q;
        replace = 1'b0;
        if (|fill_match) begin
            for (int i = 0; i < N; i++)
                if (fill_match[i]) slot = IW'(i);
        end else if (!(&valid)) begin
            for (int i = N - 1; i >= 0; i--)
                if (!valid[i]) slot = IW'(i);
        end else begin
            replace = 1'b1;
        end
    end

    // Victim pointer advances, wrapping, after each replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (fl_en && replace)
            ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + IW'(1);
    end
endmodule

// File: rtl/wtlb_store.sv
// Entry storage with valid bits, a single write port and a world-selective flush.
// Assumes a flush and a fill in one cycle: the flush applies first, the fill wins its slot.
module wtlb_store
    import wtlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  tlb_ent_t        wr_ent,
    input  logic            inv_en,
    input  logic [1:0]      inv_sel,
    output tlb_ent_t [N-1:0] ents,
    output logic [N-1:0]    valid
);
    logic [N-1:0] valid_d;

    // Next valid vector: flush by world, then set the written slot.
    always_comb begin
        valid_d = valid;
        for (int i = 0; i < N; i++) begin
            if (inv_en && ((inv_sel[INV_SEC_BIT] && ents[i].world == WORLD_SEC) ||
                           (inv_sel[INV_NRM_BIT] && ents[i].world == WORLD_NRM)))
                valid_d[i] = 1'b0;
        end
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    // Valid bits with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= '0;
        else        valid <= valid_d;
    end

    // Entry payload, written only by fills.
    always_ff @(posedge clk) begin
        if (wr_en) ents[wr_idx] <= wr_ent;
    end
endmodule

// File: rtl/wtlb_top.sv
// World-tagged fully associative TLB: combinational lookup, walker fill, flush.
// Normal-world hits are forced non-secure; secure hits return the stored NS bit.
module wtlb_top
    import wtlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_world,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_ns,
    input  logic             fl_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic             fl_ns,
    input  logic             fl_world,
    input  logic             inv_en,
    input  logic [1:0]       inv_sel
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_ent_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]     valid_q;
    logic [ENTRIES-1:0]     lk_match;
    logic [ENTRIES-1:0]     fl_match;
    logic [IW-1:0]          fl_slot;
    tlb_ent_t               fl_ent;
    logic                   sel_ns;

    assign fl_ent = '{vpn: fl_vpn, ppn: fl_ppn, world: fl_world, ns: fl_ns};

    wtlb_store #(.N(ENTRIES)) u_store (
        .clk, .rst_n, .wr_en(fl_en), .wr_idx(fl_slot), .wr_ent(fl_ent),
        .inv_en, .inv_sel, .ents, .valid(valid_q)
    );

    wtlb_match #(.N(ENTRIES)) u_lk_cmp (
        .ents, .valid(valid_q), .key_vpn(lk_vpn), .key_world(lk_world), .hit(lk_match)
    );

    wtlb_match #(.N(ENTRIES)) u_fl_cmp (
        .ents, .valid(valid_q), .key_vpn(fl_vpn), .key_world(fl_world), .hit(fl_match)
    );

    wtlb_slot_pick #(.N(ENTRIES)) u_pick (
        .clk, .rst_n, .fl_en, .valid(valid_q), .fill_match(fl_match), .slot(fl_slot)
    );

    // AND-OR read mux over the (at most one-hot) lookup matches.
    always_comb begin
        lk_ppn = '0;
        sel_ns = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_ppn = lk_ppn | ents[i].ppn;
                sel_ns = sel_ns | ents[i].ns;
            end
        end
    end

    assign lk_hit = |lk_match;
    assign lk_ns  = (lk_world == WORLD_SEC) ? sel_ns : 1'b1;
endmodule

// File: rtl/wtlb_checker.sv
// Protocol and state checks for wtlb_top, attached by bind.
// Assumes the reset is held low through the first clock edge.
module wtlb_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_world,
    input logic         lk_hit,
    input logic         lk_ns,
    input logic [N-1:0] lk_match,
    input logic [N-1:0] valid,
    input logic         inv_en,
    input logic [1:0]   inv_sel,
    input logic         fl_en
);
    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    a_r3_normal_nonsecure: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_world) |-> lk_ns);

    a_r9_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_sel == 2'b11 && !fl_en) |=> (valid == '0));

    a_r8_no_silent_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_en |=> ($countones(valid) >= $past($countones(valid))));

    a_r1_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fl_en |=> (valid != '0));
endmodule

bind wtlb_top wtlb_checker #(.N(ENTRIES)) u_chk (
    .clk, .rst_n, .lk_world, .lk_hit, .lk_ns, .lk_match, .valid(valid_q),
    .inv_en, .inv_sel, .fl_en
);

// File: tb/wtlb_top_bench.sv
module wtlb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_world = 1'b0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        lk_ns;
    logic        fl_en = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [19:0] fl_ppn = '0;
    logic        fl_ns = 1'b0;
    logic        fl_world = 1'b0;
    logic        inv_en = 1'b0;
    logic [1:0]  inv_sel = 2'b00;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wtlb_top u_wtlb_top (.*);

    typedef struct packed {
        logic        do_fill;
        logic        f_world;
        logic        f_ns;
        logic [19:0] f_vpn;
        logic [19:0] f_ppn;
        logic        l_world;
        logic [19:0] l_vpn;
        logic        e_hit;
        logic        e_ns;
        logic [19:0] e_ppn;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b0, 20'h00010, 20'h0AAAA, 1'b1, 20'h00010, 1'b1, 1'b0, 20'h0AAAA}, // R1 R5
        '{1'b0, 1'b0, 1'b0, 20'h0,     20'h0,     1'b0, 20'h00010, 1'b0, 1'b0, 20'h0},     // R2
        '{1'b1, 1'b0, 1'b0, 20'h00010, 20'h0BBBB, 1'b0, 20'h00010, 1'b1, 1'b1, 20'h0BBBB}, // R3
        '{1'b0, 1'b0, 1'b0, 20'h0,     20'h0,     1'b1, 20'h00010, 1'b1, 1'b0, 20'h0AAAA}, // R6
        '{1'b1, 1'b1, 1'b1, 20'h00020, 20'h0CCCC, 1'b1, 20'h00020, 1'b1, 1'b1, 20'h0CCCC}, // R4
        '{1'b1, 1'b1, 1'b1, 20'h00010, 20'h0DDDD, 1'b1, 20'h00010, 1'b1, 1'b1, 20'h0DDDD}, // R7
        '{1'b0, 1'b0, 1'b0, 20'h0,     20'h0,     1'b0, 20'h00020, 1'b0, 1'b0, 20'h0},     // R2
        '{1'b0, 1'b0, 1'b0, 20'h0,     20'h0,     1'b1, 20'h00099, 1'b0, 1'b0, 20'h0}      // R2
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(string req, logic w, logic [19:0] vpn, logic e_hit,
                        logic e_ns, logic [19:0] e_ppn);
        lk_world = w;
        lk_vpn   = vpn;
        #1;
        chk({req, " hit"}, 32'(lk_hit), 32'(e_hit));
        if (e_hit) begin
            chk({req, " ppn"}, 32'(lk_ppn), 32'(e_ppn));
            chk({req, " ns"}, 32'(lk_ns), 32'(e_ns));
        end
    endtask

    task automatic fill(logic w, logic [19:0] vpn, logic [19:0] ppn, logic ns);
        @(negedge clk);
        fl_en = 1'b1; fl_world = w; fl_vpn = vpn; fl_ppn = ppn; fl_ns = ns;
        @(posedge clk);
        #1 fl_en = 1'b0;
    endtask

    task automatic flush(logic [1:0] sel);
        @(negedge clk);
        inv_en = 1'b1; inv_sel = sel;
        @(posedge clk);
        #1 inv_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        look("R11 reset empty", 1'b1, 20'h00010, 1'b0, 1'b0, 20'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].do_fill) fill(VEC[i].f_world, VEC[i].f_vpn, VEC[i].f_ppn, VEC[i].f_ns);
            else @(negedge clk);
            look($sformatf("vec%0d", i), VEC[i].l_world, VEC[i].l_vpn,
                 VEC[i].e_hit, VEC[i].e_ns, VEC[i].e_ppn);
        end

        // R8: fill entries 3..7, then replacements go to entry 0, then entry 1.
        for (int i = 0; i < 5; i++) fill(1'b1, 20'h00100 + 20'(i), 20'h01100 + 20'(i), 1'b0);
        look("R8 full keeps oldest", 1'b1, 20'h00010, 1'b1, 1'b1, 20'h0DDDD);
        fill(1'b1, 20'h00200, 20'h02200, 1'b0);
        look("R8 victim entry0 gone", 1'b1, 20'h00010, 1'b0, 1'b0, 20'h0);
        look("R8 new page", 1'b1, 20'h00200, 1'b1, 1'b0, 20'h02200);
        look("R8 entry1 kept", 1'b0, 20'h00010, 1'b1, 1'b1, 20'h0BBBB);
        fill(1'b1, 20'h00201, 20'h02201, 1'b0);
        look("R8 victim entry1 gone", 1'b0, 20'h00010, 1'b0, 1'b0, 20'h0);
        look("R8 entry2 kept", 1'b1, 20'h00020, 1'b1, 1'b1, 20'h0CCCC);

        // R9: world-selective flushes.
        fill(1'b0, 20'h00300, 20'h03300, 1'b0);
        look("R9 normal resident", 1'b0, 20'h00300, 1'b1, 1'b1, 20'h03300);
        flush(2'b10);
        look("R9 normal flushed", 1'b0, 20'h00300, 1'b0, 1'b0, 20'h0);
        look("R9 secure survives", 1'b1, 20'h00104, 1'b1, 1'b0, 20'h01104);
        flush(2'b01);
        look("R9 secure flushed", 1'b1, 20'h00104, 1'b0, 1'b0, 20'h0);

        // R10: fill and lookup of one entry in the same cycle.
        fill(1'b1, 20'h00400, 20'h11111, 1'b0);
        @(negedge clk);
        fl_en = 1'b1; fl_world = 1'b1; fl_vpn = 20'h00400; fl_ppn = 20'h22222; fl_ns = 1'b1;
        look("R10 old contents", 1'b1, 20'h00400, 1'b1, 1'b0, 20'h11111);
        @(posedge clk);
        #1 fl_en = 1'b0;
        look("R10 new contents", 1'b1, 20'h00400, 1'b1, 1'b1, 20'h22222);

        // R9: flush of both worlds.
        fill(1'b0, 20'h00500, 20'h05500, 1'b1);
        flush(2'b11);
        look("R9 all secure gone", 1'b1, 20'h00400, 1'b0, 1'b0, 20'h0);
        look("R9 all normal gone", 1'b0, 20'h00500, 1'b0, 1'b0, 20'h0);

        // R11: reset in mid-run.
        fill(1'b1, 20'h00600, 20'h06600, 1'b0);
        look("R11 before reset", 1'b1, 20'h00600, 1'b1, 1'b0, 20'h06600);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        look("R11 after reset", 1'b1, 20'h00600, 1'b0, 1'b0, 20'h0);

        done = 1;
        finish_run();
    end
endmodule